// File: doc/BRIEF.md
# IDLE-aligned 32-bit word assembler

This receiver-side block rebuilds 32-bit words from a stream of 16-bit words. Each 32-bit word is carried as two 16-bit halves, and the sender never places an IDLE character between the two halves of one word. The assembler uses that rule to find word boundaries. After any IDLE, the next data word must be the first half of a new word. One IDLE after reset is enough to lock. From then on, words may follow each other back to back with no IDLEs in between, and the block keeps pairing halves.

Each input cycle presents a 16-bit word with a valid strobe and an IDLE flag. A cycle with the strobe low carries nothing. The block emits each finished 32-bit word with a one-cycle valid pulse. It raises an aligned flag once it has locked, and it pulses an error flag when an IDLE cuts a word in half.

Top module: `word_pair_assembler`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `word_valid_o`, `frame_err_o` and `aligned_o` are 0 and `word_o` is all zeros.
- R2: Before the first IDLE after reset, every data word (`valid_i`=1, `idle_i`=0) is discarded. `word_valid_o` stays 0 and `aligned_o` stays 0.
- R3: An IDLE (`valid_i`=1, `idle_i`=1) sets `aligned_o` to 1 from the next cycle on. It stays 1 until reset.
- R4: After alignment, the first data word is the first half. With the default `HIGH_FIRST`=1, the first half lands in `word_o[31:16]` and the second half in `word_o[15:0]`.
- R5: `word_valid_o` is a single-cycle pulse in the cycle after the second half is accepted. `word_o` holds its value until the next word completes.
- R6: Once aligned, words arriving back to back with no IDLEs are paired correctly, with one output word per two data words.
- R7: An IDLE that arrives after a first half and before its second half pulses `frame_err_o` for one cycle, in the cycle after the IDLE. The partial word is dropped, and the next data word is taken as a first half.
- R8: Cycles with `valid_i`=0 leave the pairing unchanged, including when they fall between two halves.
- R9: Several IDLEs in a row between words cause no error and do not shift the pairing.
- R10: `idle_i` is ignored while `valid_i` is 0. Such a cycle neither locks the block nor breaks a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Incoming 16-bit word |
| valid_i | input | 1 | Input word present this cycle |
| idle_i | input | 1 | Input word is an IDLE character |
| word_o | output | 32 | Assembled 32-bit word |
| word_valid_o | output | 1 | One-cycle pulse when `word_o` is new |
| aligned_o | output | 1 | Word boundary has been found |
| frame_err_o | output | 1 | One-cycle pulse when an IDLE splits a word |

## Verification
If the phase register is off by one half, it pairs the second half of one word with the first half of the next. The swapped halves then show on `word_o` at the very next `word_valid_o` pulse. After that pulse, every further IDLE fires `frame_err_o` within one cycle. A lock state that is stuck or lost shows on `aligned_o` one cycle after the IDLE that should have set it. The bench therefore compares every emitted word against the halves it sent, and checks the error and aligned flags in the exact cycle after each IDLE.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_FIRST,
    ST_SECOND
  } wpa_state_e;
endpackage

// File: rtl/wpa_frame_fsm.sv
module wpa_frame_fsm
  import wpa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic idle_i,
  output logic take_first_o,
  output logic take_second_o,
  output logic aligned_o,
  output logic frame_err_o
);
  wpa_state_e state_q, state_d;
  logic       is_data, is_idle, err_q;

  assign is_data = valid_i & ~idle_i;
  assign is_idle = valid_i & idle_i;

  assign take_first_o  = (state_q == ST_FIRST)  & is_data;
  assign take_second_o = (state_q == ST_SECOND) & is_data;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT:   if (is_idle) state_d = ST_FIRST;
      ST_FIRST:  if (is_data) state_d = ST_SECOND;
      ST_SECOND: if (valid_i) state_d = ST_FIRST; // data completes, idle drops partial
      default:   state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == ST_SECOND) & is_idle;
    end
  end

  assign aligned_o   = (state_q != ST_HUNT);
  assign frame_err_o = err_q;
endmodule

// File: rtl/wpa_half_store.sv
module wpa_half_store #(
  parameter int unsigned HALF_W     = 16,
  parameter bit          HIGH_FIRST = 1'b1,
  localparam int unsigned WORD_W    = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] data_i,
  input  logic              take_first_i,
  input  logic              take_second_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic [HALF_W-1:0] hold_q;
  logic [WORD_W-1:0] word_q, joined;
  logic              valid_q;

  generate
    if (HIGH_FIRST) begin : g_high_first
      assign joined = {hold_q, data_i};
    end else begin : g_low_first
      assign joined = {data_i, hold_q};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take_second_i;
      if (take_first_i)  hold_q <= data_i;
      if (take_second_i) word_q <= joined;
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;
endmodule

// File: rtl/word_pair_assembler.sv
module word_pair_assembler #(
  parameter int unsigned HALF_W     = 16,
  parameter bit          HIGH_FIRST = 1'b1,
  localparam int unsigned WORD_W    = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              idle_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              aligned_o,
  output logic              frame_err_o
);
  logic take_first, take_second;

  wpa_frame_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid_i),
    .idle_i        (idle_i),
    .take_first_o  (take_first),
    .take_second_o (take_second),
    .aligned_o     (aligned_o),
    .frame_err_o   (frame_err_o)
  );

  wpa_half_store #(.HALF_W(HALF_W), .HIGH_FIRST(HIGH_FIRST)) i_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .data_i        (data_i),
    .take_first_i  (take_first),
    .take_second_i (take_second),
    .word_o        (word_o),
    .word_valid_o  (word_valid_o)
  );
endmodule

// File: rtl/wpa_checker.sv
module wpa_checker #(
  parameter int unsigned HALF_W     = 16,
  parameter bit          HIGH_FIRST = 1'b1,
  localparam int unsigned WORD_W    = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HALF_W-1:0] data_i,
  input logic              valid_i,
  input logic              idle_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              aligned_o,
  input logic              frame_err_o
);
  logic [HALF_W-1:0] late_half;
  assign late_half = HIGH_FIRST ? word_o[HALF_W-1:0] : word_o[WORD_W-1:HALF_W];

  AST_NO_WORD_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> aligned_o); // R2
  AST_IDLE_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && idle_i) |=> aligned_o); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |=> aligned_o); // R3
  AST_SECOND_HALF_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> late_half == $past(data_i)); // R4
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o); // R5
  AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o)); // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_err_o && word_valid_o)); // R7
  AST_ERR_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> $past(valid_i && idle_i)); // R7
endmodule

bind word_pair_assembler wpa_checker #(.HALF_W(HALF_W), .HIGH_FIRST(HIGH_FIRST)) i_wpa_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .data_i       (data_i),
  .valid_i      (valid_i),
  .idle_i       (idle_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .aligned_o    (aligned_o),
  .frame_err_o  (frame_err_o)
);

// File: tb/test_word_pair_assembler.sv
module test_word_pair_assembler;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        valid_i = 1'b0;
  logic        idle_i = 1'b0;
  logic [31:0] word_o;
  logic        word_valid_o, aligned_o, frame_err_o;
  int          checks = 0;
  int          errors = 0;

  always #2 clk_i = ~clk_i;

  word_pair_assembler i_word_pair_assembler (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .idle_i(idle_i), .word_o(word_o), .word_valid_o(word_valid_o),
    .aligned_o(aligned_o), .frame_err_o(frame_err_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample just after the following posedge
  task automatic push(input logic v, input logic idl, input logic [15:0] d);
    @(negedge clk_i);
    valid_i = v; idle_i = idl; data_i = d;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    valid_i = 1'b0; idle_i = 1'b0;
  endtask

  task automatic data(input logic [15:0] d); push(1'b1, 1'b0, d); endtask
  task automatic idle(); push(1'b1, 1'b1, 16'h0); endtask
  task automatic gap(input logic idl); push(1'b0, idl, 16'hdead); endtask

  task automatic expect_word(input logic [31:0] exp, input string req);
    check(word_valid_o === 1'b1, {req, " valid"}, {31'b0, word_valid_o}, 32'h1);
    check(word_o === exp, {req, " word"}, word_o, exp);
  endtask

  task automatic expect_none(input string req);
    check(word_valid_o === 1'b0, {req, " no valid"}, {31'b0, word_valid_o}, 32'h0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #5;
    check({word_valid_o, frame_err_o, aligned_o} === 3'b000, "R1 flags in reset",
          {29'b0, word_valid_o, frame_err_o, aligned_o}, 32'h0);
    check(word_o === 32'h0, "R1 word in reset", word_o, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check({word_valid_o, frame_err_o, aligned_o} === 3'b000, "R1 flags after reset",
          {29'b0, word_valid_o, frame_err_o, aligned_o}, 32'h0);
  endtask

  task automatic t_prelock();
    for (int i = 0; i < 3; i++) begin
      data(16'h1000 + 16'(i));
      expect_none("R2");
      check(aligned_o === 1'b0, "R2 aligned", {31'b0, aligned_o}, 32'h0);
    end
    gap(1'b1);
    check(aligned_o === 1'b0, "R10 idle_i without valid", {31'b0, aligned_o}, 32'h0);
  endtask

  task automatic t_lock_first_word();
    idle();
    check(aligned_o === 1'b1, "R3 aligned after idle", {31'b0, aligned_o}, 32'h1);
    data(16'haaaa);
    expect_none("R5");
    data(16'hbbbb);
    expect_word(32'haaaabbbb, "R4");
    gap(1'b0);
    expect_none("R5 pulse");
    check(word_o === 32'haaaabbbb, "R5 hold", word_o, 32'haaaabbbb);
  endtask

  task automatic t_back_to_back();
    data(16'h0c0c); data(16'h0d0d); expect_word(32'h0c0c0d0d, "R6 first");
    data(16'h0e0e); expect_none("R6 mid");
    data(16'h0f0f); expect_word(32'h0e0e0f0f, "R6 second");
  endtask

  task automatic t_gaps_between_halves();
    data(16'h1111);
    gap(1'b0);
    gap(1'b1);
    check(frame_err_o === 1'b0, "R10 no err", {31'b0, frame_err_o}, 32'h0);
    data(16'h2222);
    expect_word(32'h11112222, "R8");
  endtask

  task automatic t_frame_error();
    data(16'h3333);
    idle();
    check(frame_err_o === 1'b1, "R7 err pulse", {31'b0, frame_err_o}, 32'h1);
    expect_none("R7 dropped");
    data(16'h4444);
    check(frame_err_o === 1'b0, "R7 err one cycle", {31'b0, frame_err_o}, 32'h0);
    expect_none("R7 realigned");
    data(16'h5555);
    expect_word(32'h44445555, "R7 next word");
  endtask

  task automatic t_multi_idle();
    for (int i = 0; i < 3; i++) begin
      idle();
      check(frame_err_o === 1'b0, "R9 no err", {31'b0, frame_err_o}, 32'h0);
    end
    data(16'h6666); data(16'h7777);
    expect_word(32'h66667777, "R9");
  endtask

  task automatic t_reset_again();
    data(16'h8888);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check(aligned_o === 1'b0, "R1 aligned cleared", {31'b0, aligned_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    data(16'h9999); data(16'haaaa);
    expect_none("R2 after reset");
    check(aligned_o === 1'b0, "R2 unaligned", {31'b0, aligned_o}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_prelock();
    t_lock_first_word();
    t_back_to_back();
    t_gaps_between_halves();
    t_frame_error();
    t_multi_idle();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule